// File: doc/BRIEF.md
# Radix-4 DIF Butterfly with On-Chip Twiddle

This unit is the arithmetic engine of one pass of a 64-point decimation-in-frequency transform. Each strobe presents a group of four complex operands, 15 bits per component in two's complement, together with the index of the group and the stride of the pass. The unit first forms the four radix-4 sums. It then rotates outputs 1, 2 and 3 by twiddle factors that it derives from its own quarter-wave sine table. Each rotated value is rounded back to a 15-bit word.

Two mode inputs are sampled with each group. One turns the twiddle rotation on for passes that need it and off for the last pass, which is a plain butterfly. The other divides every operand by four, with rounding, before the sums are formed. This gives the fixed gain reduction that one pass of the transform needs to keep its words inside 15 bits. The unit has four register stages and no stall, so it takes a new group on every clock. Stage-level data reordering and storage belong to the caller.

Top module: `r4dif_unit`

## Requirements
- R1: A group taken with `in_valid` high comes out with `out_valid` high exactly 4 clock edges later. A group is accepted on every cycle with no gaps needed, and `out_valid` is never high otherwise.
- R2: While `rst_n` is low, and for the first cycles after its release, `out_valid` is low and both output buses are zero.
- R3: Operand lane m sits in bits [15m+14:15m] of each bus, with a = lane 0, b = lane 1, c = lane 2 and d = lane 3. Before rotation the four results are y0 = a+b+c+d, y1 = a−jb−c+jd, y2 = a−b+c−d and y3 = a+jb−c−jd. Output lane m carries ym.
- R4: With `pre_shift` high, every input component x is replaced by floor((x+2)/4) before the sums are formed. With `pre_shift` low, the inputs are used unchanged.
- R5: With `tw_en` high, result m (m = 1..3) is multiplied by W = cos θ − j·sin θ, where θ = 2π·e/64 and e = (m·grp_idx·stride) mod 64. Cosine and sine are 12-bit signed values scaled so that 1.0 = 1024, each equal to 1024·|value| rounded to nearest with the sign applied.
- R6: Each rotated component is the exact complex product P reduced as floor((P+512)/1024), that is rounded to nearest with halves going up.
- R7: Lane 0 is never rotated. With `tw_en` low, no lane is rotated and the outputs are the sums themselves.
- R8: Every output component is saturated to the 15-bit range −16384..16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Group strobe |
| in_re | input | 60 | Real parts of lanes 0..3 |
| in_im | input | 60 | Imaginary parts of lanes 0..3 |
| grp_idx | input | 4 | Group index n |
| stride | input | 6 | Twiddle exponent stride s |
| tw_en | input | 1 | Apply twiddle rotation |
| pre_shift | input | 1 | Divide inputs by 4 with rounding |
| out_valid | output | 1 | Result strobe |
| out_re | output | 60 | Real parts of results 0..3 |
| out_im | output | 60 | Imaginary parts of results 0..3 |

## Verification
The bench aims at the rounding edges. Small odd negative inputs under the pre-shift would come out one off if the unit truncated, and a product that lands exactly on a half would go the wrong way if the rounding were symmetric. Full-scale inputs check saturation: a unit that wraps would turn the largest positive sum into a negative word. Exponents on the quadrant boundaries (0, 16, 32, 48) and back-to-back groups with varying stride show any sign flip in the quarter table or any result that drifts by a cycle.

// File: rtl/r4dif_pkg.sv
package r4dif_pkg;

    // Fraction bits of the twiddle words: 1.0 is 1 << TW_FRAC.
    localparam int TW_FRAC = 10;

    // First quadrant of sin(2*pi*k/64) scaled to 1024, k = 0..16.
    function automatic logic [10:0] qsine(input logic [4:0] k);
        logic [10:0] v;
        case (k)
            5'd0:    v = 11'd0;
            5'd1:    v = 11'd100;
            5'd2:    v = 11'd200;
            5'd3:    v = 11'd297;
            5'd4:    v = 11'd392;
            5'd5:    v = 11'd483;
            5'd6:    v = 11'd569;
            5'd7:    v = 11'd650;
            5'd8:    v = 11'd724;
            5'd9:    v = 11'd792;
            5'd10:   v = 11'd851;
            5'd11:   v = 11'd903;
            5'd12:   v = 11'd946;
            5'd13:   v = 11'd980;
            5'd14:   v = 11'd1004;
            5'd15:   v = 11'd1019;
            5'd16:   v = 11'd1024;
            default: v = 11'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/r4_bfly.sv
module r4_bfly #(
    parameter int DW = 15,
    parameter int BW = DW + 2
) (
    input  logic [4*DW-1:0] a_re,
    input  logic [4*DW-1:0] a_im,
    output logic [4*BW-1:0] y_re,
    output logic [4*BW-1:0] y_im
);
    logic signed [BW-1:0] xr [4];
    logic signed [BW-1:0] xi [4];

    for (genvar m = 0; m < 4; m++) begin : g_ext
        assign xr[m] = BW'($signed(a_re[m*DW +: DW]));
        assign xi[m] = BW'($signed(a_im[m*DW +: DW]));
    end

    // Forward convention: -j rotation on lane 1, +j on lane 3.
    always_comb begin
        y_re[0*BW +: BW] = xr[0] + xr[1] + xr[2] + xr[3];
        y_im[0*BW +: BW] = xi[0] + xi[1] + xi[2] + xi[3];
        y_re[1*BW +: BW] = xr[0] + xi[1] - xr[2] - xi[3];
        y_im[1*BW +: BW] = xi[0] - xr[1] - xi[2] + xr[3];
        y_re[2*BW +: BW] = xr[0] - xr[1] + xr[2] - xr[3];
        y_im[2*BW +: BW] = xi[0] - xi[1] + xi[2] - xi[3];
        y_re[3*BW +: BW] = xr[0] - xi[1] - xr[2] + xi[3];
        y_im[3*BW +: BW] = xi[0] + xr[1] - xi[2] - xr[3];
    end
endmodule

// File: rtl/r4_twiddle.sv
module r4_twiddle
    import r4dif_pkg::*;
#(
    parameter int TWW = 12,
    parameter int LGN = 6
) (
    input  logic [LGN-1:0]       expo,
    input  logic                 unity,
    output logic signed [TWW-1:0] w_re,
    output logic signed [TWW-1:0] w_im
);
    localparam logic [LGN-2:0]       QTR   = (LGN-1)'(1 << (LGN-2));
    localparam logic signed [TWW-1:0] ONE  = TWW'(1 << TW_FRAC);

    logic [1:0]             quad;
    logic [LGN-2:0]         ofs_s;
    logic [LGN-2:0]         ofs_c;
    logic signed [TWW-1:0]  sin_m;
    logic signed [TWW-1:0]  cos_m;
    logic signed [TWW-1:0]  cs;
    logic signed [TWW-1:0]  sn;

    assign quad  = expo[LGN-1 -: 2];
    assign ofs_s = {1'b0, expo[LGN-3:0]};
    assign ofs_c = QTR - ofs_s;
    assign sin_m = TWW'(qsine(5'(ofs_s)));
    assign cos_m = TWW'(qsine(5'(ofs_c)));

    always_comb begin
        unique case (quad)
            2'd0: begin cs =  cos_m; sn =  sin_m; end
            2'd1: begin cs = -sin_m; sn =  cos_m; end
            2'd2: begin cs = -cos_m; sn = -sin_m; end
            2'd3: begin cs =  sin_m; sn = -cos_m; end
        endcase
    end

    assign w_re = unity ? ONE : cs;
    assign w_im = unity ? '0  : -sn;
endmodule

// File: rtl/r4_cmul.sv
module r4_cmul
    import r4dif_pkg::*;
#(
    parameter int DW  = 15,
    parameter int BW  = DW + 2,
    parameter int TWW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [BW-1:0]  b_re,
    input  logic signed [BW-1:0]  b_im,
    input  logic signed [TWW-1:0] w_re,
    input  logic signed [TWW-1:0] w_im,
    output logic signed [DW-1:0]  y_re,
    output logic signed [DW-1:0]  y_im
);
    localparam int PW   = BW + TWW;
    localparam int SW   = PW + 1;
    localparam int HALF = 1 << (TW_FRAC - 1);
    localparam int MAXI = (1 << (DW - 1)) - 1;
    localparam logic signed [SW-1:0] MAXV = SW'(MAXI);
    localparam logic signed [SW-1:0] MINV = SW'(-MAXI - 1);

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [SW-1:0] s_re, s_im, r_re, r_im;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_rr <= '0; p_ii <= '0; p_ri <= '0; p_ir <= '0;
        end else begin
            p_rr <= PW'(b_re) * PW'(w_re);
            p_ii <= PW'(b_im) * PW'(w_im);
            p_ri <= PW'(b_re) * PW'(w_im);
            p_ir <= PW'(b_im) * PW'(w_re);
        end
    end

    assign s_re = SW'(p_rr) - SW'(p_ii);
    assign s_im = SW'(p_ri) + SW'(p_ir);
    assign r_re = (s_re + SW'(HALF)) >>> TW_FRAC;
    assign r_im = (s_im + SW'(HALF)) >>> TW_FRAC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_re <= '0;
            y_im <= '0;
        end else begin
            y_re <= (r_re > MAXV) ? MAXV[DW-1:0] : (r_re < MINV) ? MINV[DW-1:0] : r_re[DW-1:0];
            y_im <= (r_im > MAXV) ? MAXV[DW-1:0] : (r_im < MINV) ? MINV[DW-1:0] : r_im[DW-1:0];
        end
    end
endmodule

// File: rtl/r4dif_unit.sv
module r4dif_unit #(
    parameter int DW  = 15,
    parameter int TWW = 12,
    parameter int LGN = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [4*DW-1:0]       in_re,
    input  logic [4*DW-1:0]       in_im,
    input  logic [LGN-3:0]        grp_idx,
    input  logic [LGN-1:0]        stride,
    input  logic                  tw_en,
    input  logic                  pre_shift,
    output logic                  out_valid,
    output logic [4*DW-1:0]       out_re,
    output logic [4*DW-1:0]       out_im
);
    localparam int NL  = 4;
    localparam int BW  = DW + 2;
    localparam int LAT = 4;

    logic [NL*DW-1:0] s1_re, s1_im;
    logic [NL*BW-1:0] bf_re, bf_im;
    logic [LAT-1:0]   vpipe;

    for (genvar m = 0; m < NL; m++) begin : g_lane
        logic signed [DW-1:0]  xr, xi;
        logic signed [DW:0]    xr_p, xi_p, xr_s, xi_s;
        logic [LGN-1:0]        ex_c;
        logic signed [DW-1:0]  r1_re, r1_im;
        logic [LGN-1:0]        r1_ex;
        logic                  r1_one;
        logic signed [TWW-1:0] tw_re, tw_im;
        logic signed [BW-1:0]  r2_re, r2_im;
        logic signed [TWW-1:0] r2_wr, r2_wi;
        logic signed [DW-1:0]  yo_re, yo_im;

        // Stage 1: optional rounded divide by 4, exponent of this lane.
        assign xr   = in_re[m*DW +: DW];
        assign xi   = in_im[m*DW +: DW];
        assign xr_p = {xr[DW-1], xr} + (DW+1)'(2);
        assign xi_p = {xi[DW-1], xi} + (DW+1)'(2);
        assign xr_s = xr_p >>> 2;
        assign xi_s = xi_p >>> 2;
        assign ex_c = LGN'(m * int'(grp_idx) * int'(stride));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r1_re  <= '0;
                r1_im  <= '0;
                r1_ex  <= '0;
                r1_one <= 1'b1;
            end else begin
                r1_re  <= pre_shift ? xr_s[DW-1:0] : xr;
                r1_im  <= pre_shift ? xi_s[DW-1:0] : xi;
                r1_ex  <= ex_c;
                r1_one <= !tw_en || (m == 0);
            end
        end

        assign s1_re[m*DW +: DW] = r1_re;
        assign s1_im[m*DW +: DW] = r1_im;

        r4_twiddle #(.TWW(TWW), .LGN(LGN)) u_tw (
            .expo  (r1_ex),
            .unity (r1_one),
            .w_re  (tw_re),
            .w_im  (tw_im)
        );

        // Stage 2: butterfly sums and twiddle words registered together.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r2_re <= '0;
                r2_im <= '0;
                r2_wr <= '0;
                r2_wi <= '0;
            end else begin
                r2_re <= bf_re[m*BW +: BW];
                r2_im <= bf_im[m*BW +: BW];
                r2_wr <= tw_re;
                r2_wi <= tw_im;
            end
        end

        // Stages 3 and 4: products, then round and saturate.
        r4_cmul #(.DW(DW), .BW(BW), .TWW(TWW)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .b_re  (r2_re),
            .b_im  (r2_im),
            .w_re  (r2_wr),
            .w_im  (r2_wi),
            .y_re  (yo_re),
            .y_im  (yo_im)
        );

        assign out_re[m*DW +: DW] = yo_re;
        assign out_im[m*DW +: DW] = yo_im;
    end

    r4_bfly #(.DW(DW), .BW(BW)) u_bfly (
        .a_re (s1_re),
        .a_im (s1_im),
        .y_re (bf_re),
        .y_im (bf_im)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    assign out_valid = vpipe[LAT-1];
endmodule

// File: rtl/r4dif_unit_chk.sv
module r4dif_unit_chk #(
    parameter int DW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [4*DW-1:0] in_re,
    input logic [4*DW-1:0] in_im,
    input logic          tw_en,
    input logic          pre_shift,
    input logic          out_valid,
    input logic [4*DW-1:0] out_re,
    input logic [4*DW-1:0] out_im
);
    logic [2:0]             since;
    logic [3:0]             vq, zq, pq;
    logic [3:0][DW-1:0]     ar_q, ai_q;
    logic                   zero_in, pass_in;

    assign zero_in = in_valid && (in_re == '0) && (in_im == '0);
    assign pass_in = in_valid && !tw_en && !pre_shift &&
                     (in_re[4*DW-1:DW] == '0) && (in_im[4*DW-1:DW] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
            vq    <= '0;
            zq    <= '0;
            pq    <= '0;
            ar_q  <= '0;
            ai_q  <= '0;
        end else begin
            if (since != 3'd4) since <= since + 3'd1;
            vq   <= {vq[2:0], in_valid};
            zq   <= {zq[2:0], zero_in};
            pq   <= {pq[2:0], pass_in};
            ar_q <= {ar_q[2:0], in_re[DW-1:0]};
            ai_q <= {ai_q[2:0], in_im[DW-1:0]};
        end
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 3'd4) |-> (out_valid == vq[3])); // R1

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 3'd4) |-> (!out_valid && out_re == '0 && out_im == '0)); // R2

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 3'd4 && zq[3]) |-> (out_re == '0 && out_im == '0)); // R3

    AST_PASS_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 3'd4 && pq[3]) |-> (out_re == {4{ar_q[3]}} && out_im == {4{ai_q[3]}})); // R7
endmodule

bind r4dif_unit r4dif_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_re     (in_re),
    .in_im     (in_im),
    .tw_en     (tw_en),
    .pre_shift (pre_shift),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/r4dif_unit_test.sv
module r4dif_unit_test;
    localparam int PERIOD = 10;
    localparam int DW     = 15;
    localparam int LGN    = 6;
    localparam int BUSW   = 4 * DW;
    localparam int QD     = 4096;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [BUSW-1:0] in_re = '0, in_im = '0;
    logic [LGN-3:0]  grp_idx = '0;
    logic [LGN-1:0]  stride = '0;
    logic            tw_en = 1'b0, pre_shift = 1'b0;
    logic            out_valid;
    logic [BUSW-1:0] out_re, out_im;

    always #(PERIOD/2) clk = ~clk;

    r4dif_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .grp_idx(grp_idx), .stride(stride), .tw_en(tw_en), .pre_shift(pre_shift),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [BUSW-1:0] q_re [QD];
    logic [BUSW-1:0] q_im [QD];
    int              q_tag [QD];
    string           q_req [QD];
    int wr = 0, rd = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint rq(real v);
        if (v >= 0.0) return longint'($rtoi(v + 0.5));
        return -longint'($rtoi(-v + 0.5));
    endfunction

    function automatic longint sat(longint v);
        if (v > 16383) return 16383;
        if (v < -16384) return -16384;
        return v;
    endfunction

    function automatic logic [BUSW-1:0] pack4(int l0, int l1, int l2, int l3);
        return {DW'(l3), DW'(l2), DW'(l1), DW'(l0)};
    endfunction

    task automatic model(input logic [BUSW-1:0] xr, input logic [BUSW-1:0] xi,
                         input int n, input int s, input bit ps, input bit te,
                         output logic [BUSW-1:0] yr, output logic [BUSW-1:0] yi);
        longint ar[4], ai[4], br[4], bi[4];
        for (int m = 0; m < 4; m++) begin
            ar[m] = longint'($signed(xr[m*DW +: DW]));
            ai[m] = longint'($signed(xi[m*DW +: DW]));
            if (ps) begin
                ar[m] = (ar[m] + 2) >>> 2;
                ai[m] = (ai[m] + 2) >>> 2;
            end
        end
        br[0] = ar[0] + ar[1] + ar[2] + ar[3];  bi[0] = ai[0] + ai[1] + ai[2] + ai[3];
        br[1] = ar[0] + ai[1] - ar[2] - ai[3];  bi[1] = ai[0] - ar[1] - ai[2] + ar[3];
        br[2] = ar[0] - ar[1] + ar[2] - ar[3];  bi[2] = ai[0] - ai[1] + ai[2] - ai[3];
        br[3] = ar[0] - ai[1] - ar[2] + ai[3];  bi[3] = ai[0] + ar[1] - ai[2] - ar[3];
        for (int m = 0; m < 4; m++) begin
            longint rr, ri;
            if (te && m > 0) begin
                int e;
                real th;
                longint wr_, wi_;
                e   = (m * n * s) % 64;
                th  = 2.0 * 3.14159265358979323846 * real'(e) / 64.0;
                wr_ = rq(1024.0 * $cos(th));
                wi_ = -rq(1024.0 * $sin(th));
                rr  = (br[m] * wr_ - bi[m] * wi_ + 512) >>> 10;
                ri  = (br[m] * wi_ + bi[m] * wr_ + 512) >>> 10;
            end else begin
                rr = br[m];
                ri = bi[m];
            end
            yr[m*DW +: DW] = DW'(sat(rr));
            yi[m*DW +: DW] = DW'(sat(ri));
        end
    endtask

    task automatic send(input logic [BUSW-1:0] xr, input logic [BUSW-1:0] xi,
                        input int n, input int s, input bit ps, input bit te, input string req);
        logic [BUSW-1:0] er, ei;
        @(negedge clk);
        in_valid  = 1'b1;
        in_re     = xr;
        in_im     = xi;
        grp_idx   = (LGN-2)'(n);
        stride    = LGN'(s);
        pre_shift = ps;
        tw_en     = te;
        model(xr, xi, n, s, ps, te, er, ei);
        q_re[wr]  = er;
        q_im[wr]  = ei;
        q_tag[wr] = cyc + 4;
        q_req[wr] = req;
        wr++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_re    = {$urandom, $urandom};
            in_im    = {$urandom, $urandom};
            tw_en    = $urandom % 2;
        end
    endtask

    // Output monitor, sampled a quarter period after the rising edge.
    always begin
        @(posedge clk);
        #(PERIOD/4);
        if (rst_n) begin
            if (rd < wr && q_tag[rd] == cyc) begin
                checks++;
                if (!out_valid) begin
                    fails++;
                    $display("FAIL R1 (%s) out_valid missing at cycle %0d: got 0 expected 1", q_req[rd], cyc);
                end else if (out_re !== q_re[rd] || out_im !== q_im[rd]) begin
                    fails++;
                    $display("FAIL %s re got %h expected %h, im got %h expected %h",
                             q_req[rd], out_re, q_re[rd], out_im, q_im[rd]);
                end
                rd++;
            end else if (out_valid) begin
                checks++;
                fails++;
                $display("FAIL R1 unexpected out_valid at cycle %0d: got 1 expected 0", cyc);
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
            fails++;
            $display("FAIL R2 reset outputs got v=%b re=%h expected v=0 re=0", out_valid, out_re);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
            fails++;
            $display("FAIL R2 after release got v=%b re=%h expected v=0 re=0", out_valid, out_re);
        end

        // R3/R7: lone lane 0 passes to every lane without rotation.
        send(pack4(1000, 0, 0, 0), pack4(-77, 0, 0, 0), 5, 1, 0, 0, "R7 lane0 passthrough");
        // R3: each lane alone, no rotation.
        send(pack4(0, 300, 0, 0), pack4(0, 20, 0, 0), 0, 1, 0, 0, "R3 lane1 impulse");
        send(pack4(0, 0, 300, 0), pack4(0, 0, -20, 0), 0, 1, 0, 0, "R3 lane2 impulse");
        send(pack4(0, 0, 0, 300), pack4(0, 0, 0, 20), 0, 1, 0, 0, "R3 lane3 impulse");
        send('0, '0, 9, 7, 1, 1, "R3 zero input");
        // R4: rounding of the divide by 4 on small odd values.
        send(pack4(-3, 2, 1, -2), pack4(5, -5, 6, -6), 0, 1, 1, 0, "R4 preshift rounding");
        send(pack4(16383, -16384, 7, -7), pack4(-1, 1, 3, -3), 0, 1, 1, 0, "R4 preshift extremes");
        // R5/R6: quadrant boundaries e = 16, 32, 48 and a twiddle with n = 0.
        send(pack4(1000, 0, 0, 0), pack4(0, 0, 0, 0), 1, 16, 0, 1, "R5 quadrant edges");
        send(pack4(4000, 0, 0, 0), pack4(-2500, 0, 0, 0), 1, 1, 0, 1, "R5 first-octant twiddles");
        send(pack4(511, 0, 0, 0), pack4(513, 0, 0, 0), 3, 5, 0, 1, "R6 product rounding");
        send(pack4(1234, 55, -999, 8), pack4(-4, 700, 21, -3000), 0, 13, 0, 1, "R7 twiddle with n=0");
        // R8: saturation at both ends, with and without rotation.
        send(pack4(16383, 16383, 16383, 16383), '0, 0, 1, 0, 0, "R8 positive saturation");
        send(pack4(-16384, -16384, -16384, -16384), '0, 0, 1, 0, 0, "R8 negative saturation");
        send(pack4(16383, 16383, -16384, -16384), pack4(16383, -16384, 16383, -16384), 2, 3, 0, 1, "R8 rotated saturation");
        idle(3);

        // R1: continuous stream plus random gaps, random modes.
        for (int i = 0; i < 1500; i++) begin
            int s;
            case ($urandom % 4)
                0: s = 1;
                1: s = 4;
                2: s = 16;
                default: s = $urandom % 64;
            endcase
            if (i > 200 && ($urandom % 4) == 0) idle(1 + $urandom % 3);
            send({$urandom, $urandom}, {$urandom, $urandom}, $urandom % 16, s,
                 $urandom % 2, $urandom % 2, "R5/R6 random group");
        end
        idle(10);

        checks++;
        if (rd != wr) begin
            fails++;
            $display("FAIL R1 groups delivered got %0d expected %0d", rd, wr);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule